// File: doc/BRIEF.md
# Capture/Compare Event Flag Register

This block holds the capture/compare event flags of a multi-channel timer. Every channel owns two general registers, called slot C and slot D here, and each slot has one sticky flag. A flag is raised when its slot sees a compare match while the slot is in compare mode. It is also raised when its slot sees a capture strobe while the slot is in capture mode.

Software lowers a flag in two steps. It first reads the channel's status and sees the flag at 1, which arms that flag. A later write of 0 to the flag's bit then clears it. A transfer controller that services the flag's interrupt can also lower the flag, unless its disable-clear input is high.

Each channel's status reads back with slot C at bit 2 and slot D at bit 3. A parameter mask selects which channels actually implement the two flags. Each flag drives one interrupt request, gated by its own enable input.

Top module: `cc_flag_status`

## Requirements
- R1: A slot in compare mode (mode_cap_i bit = 0) whose match_i strobe is high at a clock edge has its flag at 1 after that edge.
- R2: A slot in capture mode (mode_cap_i bit = 1) sets its flag on capture_i. In capture mode match_i is ignored, and in compare mode capture_i is ignored.
- R3: Writing 1 to a flag bit never changes that flag, even when the flag is armed.
- R4: Writing 0 to a flag bit clears the flag only if it is armed. Any write to the flag's channel consumes the arm, whatever the written data.
- R5: A service strobe on svc_i clears its flag when svc_noclr_i is 0. When svc_noclr_i is 1, the strobe leaves the flag unchanged.
- R6: A set event and a clear (by software or by the controller) in the same cycle leave the flag at 1.
- R7: rdata_o combinationally shows the channel addressed by sel_i, with slot C at bit 2 and slot D at bit 3. All other bits read 0, and a sel_i past the last channel reads all 0.
- R8: In channels whose CD_MASK bit is 0, both flags read 0, their irq_o bits are 0, and events, services and writes have no effect.
- R9: After reset every flag and every arm is 0.
- R10: irq_o[2*ch+s] equals the flag of slot s (0 = C, 1 = D) of channel ch ANDed with irq_en_i of the same index.
- R11: A read of a channel arms only the flags that are 1 at that read. A read that sees 0 does not arm, so a later write of 0 leaves a flag that was set after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_cap_i | input | 2*NUM_CH | Per slot: 1 = capture mode, 0 = compare mode; index 2*ch+s |
| match_i | input | 2*NUM_CH | Per slot compare-match strobe |
| capture_i | input | 2*NUM_CH | Per slot input-capture strobe |
| svc_i | input | 2*NUM_CH | Per slot transfer-controller service strobe |
| svc_noclr_i | input | 1 | Controller disable-clear bit; 1 blocks service clears |
| irq_en_i | input | 2*NUM_CH | Per slot interrupt enable |
| rd_i | input | 1 | Bus read of the channel in sel_i |
| wr_i | input | 1 | Bus write of the channel in sel_i |
| sel_i | input | SEL_W | Channel select for read and write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Status of the selected channel |
| irq_o | output | 2*NUM_CH | Per slot interrupt request |

## Verification
The bench uses the defaults: six channels, CD_MASK = 6'b001001 (flags in channels 0 and 3 only), and an 8-bit data width. With these values a 3-bit select can address two channels that do not exist, which reaches the out-of-range read path. The mask puts implemented and absent channels side by side. Random traffic mixes reads, writes and service strobes with set events in both modes, so arm consumption and same-cycle set/clear collisions occur often on both slots.

// File: rtl/cc_flag_pkg.sv
`timescale 1ns/1ps
package cc_flag_pkg;
  localparam int unsigned SLOT_C = 0;
  localparam int unsigned SLOT_D = 1;
  localparam int unsigned SLOTS  = 2;
  // bit positions decoded by software
  localparam int unsigned BIT_C  = 2;
  localparam int unsigned BIT_D  = 3;

  function automatic int unsigned slot_bit(input int unsigned s);
    return (s == SLOT_C) ? BIT_C : BIT_D;
  endfunction
endpackage

// File: rtl/cc_flag_cell.sv
`timescale 1ns/1ps
module cc_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_cap_i,
  input  logic match_i,
  input  logic capture_i,
  input  logic svc_i,
  input  logic svc_noclr_i,
  input  logic irq_en_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, arm_q, flag_d, arm_d;
  logic set_ev, sw_clr, hw_clr;

  always_comb begin
    set_ev = mode_cap_i ? capture_i : match_i;
    sw_clr = wr_hit_i & ~wbit_i & arm_q;
    hw_clr = svc_i & ~svc_noclr_i;
    // set has priority so no event is lost
    flag_d = set_ev | (flag_q & ~(sw_clr | hw_clr));
    // any write consumes the arm; a read arms only on a visible 1
    arm_d  = wr_hit_i ? 1'b0 : (arm_q | (rd_hit_i & flag_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  // R1 R2 R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> flag_q);
  // R3
  wr_one_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_hit_i && wbit_i && !svc_i) |=> flag_q);
  // R4
  unarmed_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_hit_i && !arm_q && !svc_i) |=> flag_q);
  // R4
  arm_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> !arm_q);
  // R5
  svc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !svc_noclr_i && !set_ev) |=> !flag_q);
  // R5
  svc_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && svc_i && svc_noclr_i && !wr_hit_i) |=> flag_q);
endmodule

// File: rtl/cc_flag_chan.sv
`timescale 1ns/1ps
module cc_flag_chan
  import cc_flag_pkg::*;
#(
  parameter bit HAS_CD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] mode_cap_i,
  input  logic [SLOTS-1:0] match_i,
  input  logic [SLOTS-1:0] capture_i,
  input  logic [SLOTS-1:0] svc_i,
  input  logic             svc_noclr_i,
  input  logic [SLOTS-1:0] irq_en_i,
  input  logic             rd_hit_i,
  input  logic             wr_hit_i,
  input  logic [SLOTS-1:0] wbits_i,
  output logic [SLOTS-1:0] flag_o,
  output logic [SLOTS-1:0] irq_o
);
  if (HAS_CD) begin : g_cd
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      cc_flag_cell u_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_cap_i  (mode_cap_i[s]),
        .match_i     (match_i[s]),
        .capture_i   (capture_i[s]),
        .svc_i       (svc_i[s]),
        .svc_noclr_i (svc_noclr_i),
        .irq_en_i    (irq_en_i[s]),
        .rd_hit_i    (rd_hit_i),
        .wr_hit_i    (wr_hit_i),
        .wbit_i      (wbits_i[s]),
        .flag_o      (flag_o[s]),
        .irq_o       (irq_o[s])
      );
    end
  end else begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, mode_cap_i, match_i, capture_i, svc_i,
                         svc_noclr_i, irq_en_i, rd_hit_i, wr_hit_i, wbits_i};
    assign flag_o = '0;
    assign irq_o  = '0;
  end
endmodule

// File: rtl/cc_flag_rdmux.sv
`timescale 1ns/1ps
module cc_flag_rdmux
  import cc_flag_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DW     = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [SLOTS*NUM_CH-1:0] flags_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [DW-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_i == SEL_W'(c)) begin
        for (int s = 0; s < SLOTS; s++) begin
          rdata_o[slot_bit(s)] = flags_i[SLOTS*c + s];
        end
      end
    end
  end
endmodule

// File: rtl/cc_flag_status.sv
`timescale 1ns/1ps
module cc_flag_status
  import cc_flag_pkg::*;
#(
  parameter int unsigned       NUM_CH  = 6,
  parameter logic [NUM_CH-1:0] CD_MASK = NUM_CH'(9),
  parameter int unsigned       DW      = 8,
  localparam int unsigned      SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned      NF      = SLOTS * NUM_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NF-1:0]    mode_cap_i,
  input  logic [NF-1:0]    match_i,
  input  logic [NF-1:0]    capture_i,
  input  logic [NF-1:0]    svc_i,
  input  logic             svc_noclr_i,
  input  logic [NF-1:0]    irq_en_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NF-1:0]    irq_o
);
  logic [NF-1:0]    flags;
  logic [SLOTS-1:0] wbits;
  logic             unused_wdata;

  for (genvar s = 0; s < SLOTS; s++) begin : g_wb
    assign wbits[s] = wdata_i[slot_bit(s)];
  end
  assign unused_wdata = ^wdata_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [SEL_W-1:0] CH_ID = SEL_W'(c);
    logic rd_hit, wr_hit;
    assign rd_hit = rd_i & (sel_i == CH_ID);
    assign wr_hit = wr_i & (sel_i == CH_ID);

    cc_flag_chan #(.HAS_CD(CD_MASK[c])) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_cap_i  (mode_cap_i[SLOTS*c +: SLOTS]),
      .match_i     (match_i[SLOTS*c +: SLOTS]),
      .capture_i   (capture_i[SLOTS*c +: SLOTS]),
      .svc_i       (svc_i[SLOTS*c +: SLOTS]),
      .svc_noclr_i (svc_noclr_i),
      .irq_en_i    (irq_en_i[SLOTS*c +: SLOTS]),
      .rd_hit_i    (rd_hit),
      .wr_hit_i    (wr_hit),
      .wbits_i     (wbits),
      .flag_o      (flags[SLOTS*c +: SLOTS]),
      .irq_o       (irq_o[SLOTS*c +: SLOTS])
    );
  end

  cc_flag_rdmux #(.NUM_CH(NUM_CH), .DW(DW), .SEL_W(SEL_W)) u_rdmux (
    .flags_i (flags),
    .sel_i   (sel_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/cc_flag_status_tb.sv
`timescale 1ns/1ps
module cc_flag_status_tb;
  localparam int NCH = 6;
  localparam int NF  = 2 * NCH;
  localparam logic [NCH-1:0] MASK = 6'b001001;

  logic clk_i = 0, rst_ni = 0;
  logic [NF-1:0] mode_cap_i, match_i, capture_i, svc_i, irq_en_i, irq_o;
  logic svc_noclr_i, rd_i, wr_i;
  logic [2:0] sel_i;
  logic [7:0] wdata_i, rdata_o;

  int total = 0, bad = 0;
  bit mflag [NF];
  bit marm  [NF];

  always #10 clk_i = ~clk_i;

  cc_flag_status u_dut (.*);

  function automatic logic [7:0] exp_rd(input int ch);
    logic [7:0] r = 8'h00;
    if (ch < NCH && MASK[ch]) begin
      r[2] = mflag[2*ch];
      r[3] = mflag[2*ch+1];
    end
    return r;
  endfunction

  function automatic logic [NF-1:0] exp_irq();
    logic [NF-1:0] v;
    for (int k = 0; k < NF; k++) v[k] = mflag[k] & irq_en_i[k];
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    match_i = '0; capture_i = '0; svc_i = '0; svc_noclr_i = 0;
    rd_i = 0; wr_i = 0; wdata_i = '0;
  endtask

  task automatic model_step();
    bit nf [NF];
    bit na [NF];
    for (int k = 0; k < NF; k++) begin
      int ch = k / 2;
      bit sev, rh, wh, clr;
      nf[k] = 0; na[k] = 0;
      if (MASK[ch]) begin
        sev = mode_cap_i[k] ? capture_i[k] : match_i[k];
        rh  = rd_i && (sel_i == 3'(ch));
        wh  = wr_i && (sel_i == 3'(ch));
        clr = (wh && !wdata_i[2 + k%2] && marm[k]) || (svc_i[k] && !svc_noclr_i);
        nf[k] = sev ? 1'b1 : (clr ? 1'b0 : mflag[k]);
        na[k] = wh ? 1'b0 : (marm[k] | (rh & mflag[k]));
      end
    end
    for (int k = 0; k < NF; k++) begin mflag[k] = nf[k]; marm[k] = na[k]; end
  endtask

  // inputs set at negedge; compare combinational outputs, then advance
  task automatic cyc();
    #1;
    chk(rdata_o, exp_rd(sel_i), "R7");
    chk(irq_o, exp_irq(), "R10");
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic peek(input int ch, input logic [7:0] exp, input string req);
    sel_i = 3'(ch);
    #1;
    chk(rdata_o, exp, req);
    chk(rdata_o, exp_rd(ch), req);
  endtask

  task automatic do_rd(input int ch);
    sel_i = 3'(ch); rd_i = 1; cyc();
  endtask

  task automatic do_wr(input int ch, input logic [7:0] d);
    sel_i = 3'(ch); wr_i = 1; wdata_i = d; cyc();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    mode_cap_i = '0; irq_en_i = '0; sel_i = '0;
    for (int k = 0; k < NF; k++) begin mflag[k] = 0; marm[k] = 0; end
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    for (int c = 0; c < 8; c++) peek(c, 8'h00, "R9");
    chk(irq_o, '0, "R9");

    match_i[0] = 1; cyc();
    peek(0, 8'h04, "R1");

    do_wr(0, 8'h00);                       // not armed
    peek(0, 8'h04, "R4");

    do_rd(0);
    do_wr(0, 8'hFF);
    peek(0, 8'h04, "R3");
    do_wr(0, 8'h00);                       // arm consumed by the previous write
    peek(0, 8'h04, "R4");
    do_rd(0);
    do_wr(0, 8'h00);
    peek(0, 8'h00, "R4");

    mode_cap_i[7] = 1;
    match_i[7] = 1; cyc();
    peek(3, 8'h00, "R2");
    capture_i[7] = 1; cyc();
    peek(3, 8'h08, "R2");

    irq_en_i[7] = 1; #1;
    chk(irq_o[7], 1'b1, "R10");
    irq_en_i[7] = 0; #1;
    chk(irq_o[7], 1'b0, "R10");

    svc_i[7] = 1; svc_noclr_i = 1; cyc();
    peek(3, 8'h08, "R5");
    svc_i[7] = 1; svc_noclr_i = 0; cyc();
    peek(3, 8'h00, "R5");

    svc_i[6] = 1; match_i[6] = 1; cyc();
    peek(3, 8'h04, "R6");
    do_rd(3);
    sel_i = 3; wr_i = 1; wdata_i = 8'h00; match_i[6] = 1; cyc();
    peek(3, 8'h04, "R6");

    do_rd(0);                              // sees 0, must not arm
    match_i[0] = 1; cyc();
    do_wr(0, 8'h00);
    peek(0, 8'h04, "R11");

    irq_en_i = '1;
    match_i[5:2] = 4'hF; capture_i[5:2] = 4'hF; mode_cap_i[3] = 1; cyc();
    peek(1, 8'h00, "R8");
    peek(2, 8'h00, "R8");
    chk(irq_o[5:2], 4'h0, "R8");
    do_wr(1, 8'hFF);
    peek(1, 8'h00, "R8");
    irq_en_i = '0;

    match_i[1] = 1; cyc();
    peek(0, 8'h0C, "R7");
    peek(7, 8'h00, "R7");

    for (int i = 0; i < 5000; i++) begin
      if ($urandom % 64 == 0) mode_cap_i = NF'($urandom);
      for (int k = 0; k < NF; k++) begin
        match_i[k]   = ($urandom % 8 == 0);
        capture_i[k] = ($urandom % 8 == 0);
        svc_i[k]     = ($urandom % 12 == 0);
      end
      irq_en_i    = NF'($urandom);
      svc_noclr_i = $urandom % 2;
      rd_i        = ($urandom % 10) < 4;
      wr_i        = ($urandom % 10) < 3;
      sel_i       = 3'($urandom);
      wdata_i     = 8'($urandom);
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule